// File: doc/BRIEF.md
# LIN Frame Data Buffer

This block is the byte store between a LIN/UART controller's serial engine and the CPU. It keeps eight data bytes. Software reaches them through two registers. The select register holds a 3-bit pointer and a hold bit. The data register reads or writes the byte that the pointer selects. When the hold bit is 0, the pointer steps forward after every data access and wraps at the end of the buffer. When the hold bit is 1, the pointer stays where it is, and software sets it before each access.

The serial engine has its own port and its own byte counter. A frame-start pulse returns that counter to slot 0. Received bytes are then stored in arrival order, and bytes to transmit are fetched in the same order. When both sides write one byte in the same cycle, the engine's write is kept.

In UART mode the pointer and the buffer are not used. A data-register write loads an outgoing byte and raises a one-cycle load strobe. A data-register read returns the last byte received.

Top module: `lin_frame_buf`

## Requirements
- R1: After reset the select register reads 0, all eight buffer bytes read 0, the frame counter is 0, and the UART transmit byte and load strobe are 0.
- R2: In frame mode, `dat_rdata_o` shows the byte at the current pointer in the same cycle. A data write stores `dat_wdata_i` into that byte at the next clock edge.
- R3: In frame mode with the hold bit (`sel_wdata_i[3]`) at 0, each cycle with `dat_we_i` or `dat_re_i` high advances the pointer (`sel_rdata_o[2:0]`) by one at the next edge.
- R4: A pointer advance from 7 gives 0.
- R5: With the hold bit at 1, data accesses leave the pointer unchanged.
- R6: A select-register write replaces the hold bit and the pointer at the next edge. It takes priority over an advance requested in the same cycle.
- R7: The frame counter `frm_idx_o` goes to 0 on `frm_start_i`. When a strobe is present in that cycle, the strobe uses slot 0 and the counter ends at 1. Each `frm_rx_we_i` stores its byte at the counter and advances the counter by one with wrap, so the bytes of a frame land in slots 0, 1, 2 and so on. The CPU pointer does not affect the frame counter.
- R8: `frm_tx_data_o` shows the byte at the frame counter in the same cycle. A `frm_tx_re_i` advances the counter.
- R9: When the CPU and the frame port write the same byte in one cycle, the byte holds the frame-port data afterwards.
- R10: In UART mode (`uart_mode_i`=1), a data write loads `uart_tx_data_o` and pulses `uart_tx_load_o` for one cycle at the next edge. Data accesses change neither the pointer nor any buffer byte.
- R11: In UART mode, `dat_rdata_o` returns the byte last captured while `uart_rx_valid_i` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uart_mode_i | input | 1 | 1 selects UART mode, 0 selects frame-buffer mode |
| sel_we_i | input | 1 | Select-register write strobe |
| sel_wdata_i | input | 4 | Bit 3 is the hold bit, bits 2:0 are the pointer |
| sel_rdata_o | output | 4 | Select-register contents, same layout as the write data |
| dat_we_i | input | 1 | Data-register write strobe |
| dat_re_i | input | 1 | Data-register read strobe |
| dat_wdata_i | input | 8 | Data-register write byte |
| dat_rdata_o | output | 8 | Data-register read byte |
| frm_start_i | input | 1 | Frame-start pulse; returns the frame counter to 0 |
| frm_rx_we_i | input | 1 | Received-byte store strobe |
| frm_rx_data_i | input | 8 | Received byte |
| frm_tx_re_i | input | 1 | Transmit-byte fetch strobe |
| frm_tx_data_o | output | 8 | Byte at the frame counter |
| frm_idx_o | output | 3 | Frame counter |
| uart_rx_valid_i | input | 1 | UART received-byte strobe |
| uart_rx_data_i | input | 8 | UART received byte |
| uart_tx_data_o | output | 8 | UART outgoing byte |
| uart_tx_load_o | output | 1 | One-cycle pulse when a new outgoing byte has been loaded |

## Verification
The assertions assume that the strobes are clean, synchronous, one-cycle controls. They also assume that the pointer reported on `sel_rdata_o` moves only through a select write or an advance. They make no assumption about the order of data accesses. The stimulus draws every strobe at random from a fixed seed. Select writes are kept rare so that long runs of auto-increment and wrap take place. Mode changes happen only at cycle boundaries. Directed phases force the same-byte write collision, a full wrap of the pointer, and frame starts that coincide with strobes.

// File: rtl/lin_buf_pkg.sv
package lin_buf_pkg;
  localparam int unsigned LIN_DEPTH  = 8;
  localparam int unsigned LIN_DATA_W = 8;

  typedef enum logic {
    MODE_FRAME = 1'b0,
    MODE_UART  = 1'b1
  } lin_mode_e;
endpackage

// File: rtl/lin_buf_sel.sv
module lin_buf_sel #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             uart_i,
  input  logic             sel_we_i,
  input  logic [IDX_W:0]   sel_wdata_i,
  input  logic             access_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             hold_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q;
  logic             hold_q;
  logic             step;

  assign step = access_i && !uart_i && !hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      hold_q <= 1'b0;
    end else if (sel_we_i) begin
      idx_q  <= sel_wdata_i[IDX_W-1:0];
      hold_q <= sel_wdata_i[IDX_W];
    end else if (step) begin
      idx_q  <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/lin_buf_frm_ctr.sv
module lin_buf_frm_ctr #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] eff_idx_o,
  output logic [IDX_W-1:0] cnt_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] cnt_q;

  // a start pulse redirects any strobe in the same cycle to slot 0
  assign eff_idx_o = start_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= (eff_idx_o == LAST) ? '0 : eff_idx_o + 1'b1;
    end else if (start_i) begin
      cnt_q <= '0;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lin_buf_mem.sv
module lin_buf_mem #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_we_i,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              frm_we_i,
  input  logic [IDX_W-1:0]  frm_idx_i,
  input  logic [DATA_W-1:0] frm_wdata_i,
  output logic [DATA_W-1:0] frm_rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    logic hit_cpu, hit_frm;
    assign hit_cpu = cpu_we_i && (cpu_idx_i == IDX_W'(g));
    assign hit_frm = frm_we_i && (frm_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mem_q[g] <= '0;
      else if (hit_frm) mem_q[g] <= frm_wdata_i;  // engine side wins
      else if (hit_cpu) mem_q[g] <= cpu_wdata_i;
    end
  end

  assign cpu_rdata_o = mem_q[cpu_idx_i];
  assign frm_rdata_o = mem_q[frm_idx_i];
endmodule

// File: rtl/lin_buf_uart_reg.sv
module lin_buf_uart_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uart_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic [DATA_W-1:0] rx_hold_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_load_o
);
  logic [DATA_W-1:0] rx_q, tx_q;
  logic              load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q   <= '0;
      tx_q   <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= uart_i && we_i;
      if (uart_i && we_i) tx_q <= wdata_i;
      if (rx_valid_i)     rx_q <= rx_data_i;
    end
  end

  assign rx_hold_o = rx_q;
  assign tx_data_o = tx_q;
  assign tx_load_o = load_q;
endmodule

// File: rtl/lin_frame_buf.sv
module lin_frame_buf
  import lin_buf_pkg::*;
#(
  parameter int unsigned DEPTH  = LIN_DEPTH,
  parameter int unsigned DATA_W = LIN_DATA_W,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uart_mode_i,
  input  logic              sel_we_i,
  input  logic [IDX_W:0]    sel_wdata_i,
  output logic [IDX_W:0]    sel_rdata_o,
  input  logic              dat_we_i,
  input  logic              dat_re_i,
  input  logic [DATA_W-1:0] dat_wdata_i,
  output logic [DATA_W-1:0] dat_rdata_o,
  input  logic              frm_start_i,
  input  logic              frm_rx_we_i,
  input  logic [DATA_W-1:0] frm_rx_data_i,
  input  logic              frm_tx_re_i,
  output logic [DATA_W-1:0] frm_tx_data_o,
  output logic [IDX_W-1:0]  frm_idx_o,
  input  logic              uart_rx_valid_i,
  input  logic [DATA_W-1:0] uart_rx_data_i,
  output logic [DATA_W-1:0] uart_tx_data_o,
  output logic              uart_tx_load_o
);
  lin_mode_e         mode;
  logic              is_uart;
  logic [IDX_W-1:0]  cpu_idx, frm_eff;
  logic              cpu_hold;
  logic [DATA_W-1:0] buf_rdata, rx_hold;

  assign mode    = lin_mode_e'(uart_mode_i);
  assign is_uart = (mode == MODE_UART);

  lin_buf_sel #(.DEPTH(DEPTH)) i_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .uart_i      (is_uart),
    .sel_we_i    (sel_we_i),
    .sel_wdata_i (sel_wdata_i),
    .access_i    (dat_we_i | dat_re_i),
    .idx_o       (cpu_idx),
    .hold_o      (cpu_hold)
  );

  lin_buf_frm_ctr #(.DEPTH(DEPTH)) i_frm_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (frm_start_i),
    .step_i    (frm_rx_we_i | frm_tx_re_i),
    .eff_idx_o (frm_eff),
    .cnt_o     (frm_idx_o)
  );

  lin_buf_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_we_i    (dat_we_i && !is_uart),
    .cpu_idx_i   (cpu_idx),
    .cpu_wdata_i (dat_wdata_i),
    .cpu_rdata_o (buf_rdata),
    .frm_we_i    (frm_rx_we_i),
    .frm_idx_i   (frm_eff),
    .frm_wdata_i (frm_rx_data_i),
    .frm_rdata_o (frm_tx_data_o)
  );

  lin_buf_uart_reg #(.DATA_W(DATA_W)) i_uart (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .uart_i     (is_uart),
    .we_i       (dat_we_i),
    .wdata_i    (dat_wdata_i),
    .rx_valid_i (uart_rx_valid_i),
    .rx_data_i  (uart_rx_data_i),
    .rx_hold_o  (rx_hold),
    .tx_data_o  (uart_tx_data_o),
    .tx_load_o  (uart_tx_load_o)
  );

  assign sel_rdata_o = {cpu_hold, cpu_idx};
  assign dat_rdata_o = is_uart ? rx_hold : buf_rdata;
endmodule

// File: rtl/lin_frame_buf_chk.sv
module lin_frame_buf_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              uart_mode_i,
  input logic              sel_we_i,
  input logic [IDX_W:0]    sel_wdata_i,
  input logic [IDX_W:0]    sel_rdata_o,
  input logic              dat_we_i,
  input logic              dat_re_i,
  input logic [DATA_W-1:0] dat_wdata_i,
  input logic              frm_start_i,
  input logic              frm_rx_we_i,
  input logic              frm_tx_re_i,
  input logic [IDX_W-1:0]  frm_idx_o,
  input logic [DATA_W-1:0] uart_tx_data_o,
  input logic              uart_tx_load_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  assert_auto_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uart_mode_i && !sel_we_i && !sel_rdata_o[IDX_W] && (dat_we_i || dat_re_i)
      && sel_rdata_o[IDX_W-1:0] != LAST)
    |=> sel_rdata_o[IDX_W-1:0] == $past(sel_rdata_o[IDX_W-1:0]) + 1'b1);

  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uart_mode_i && !sel_we_i && !sel_rdata_o[IDX_W] && (dat_we_i || dat_re_i)
      && sel_rdata_o[IDX_W-1:0] == LAST)
    |=> sel_rdata_o[IDX_W-1:0] == '0);

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_rdata_o[IDX_W] && !sel_we_i) |=> $stable(sel_rdata_o));

  assert_sel_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i |=> sel_rdata_o == $past(sel_wdata_i));

  assert_frame_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_start_i && !frm_rx_we_i && !frm_tx_re_i) |=> frm_idx_o == '0);

  assert_frame_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frm_start_i && !frm_rx_we_i && !frm_tx_re_i) |=> $stable(frm_idx_o));

  assert_uart_ptr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_mode_i && !sel_we_i) |=> $stable(sel_rdata_o));

  assert_uart_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_mode_i && dat_we_i) |=> uart_tx_load_o && uart_tx_data_o == $past(dat_wdata_i));

  assert_uart_noload_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(uart_mode_i && dat_we_i) |=> !uart_tx_load_o);
endmodule

bind lin_frame_buf lin_frame_buf_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .uart_mode_i    (uart_mode_i),
  .sel_we_i       (sel_we_i),
  .sel_wdata_i    (sel_wdata_i),
  .sel_rdata_o    (sel_rdata_o),
  .dat_we_i       (dat_we_i),
  .dat_re_i       (dat_re_i),
  .dat_wdata_i    (dat_wdata_i),
  .frm_start_i    (frm_start_i),
  .frm_rx_we_i    (frm_rx_we_i),
  .frm_tx_re_i    (frm_tx_re_i),
  .frm_idx_o      (frm_idx_o),
  .uart_tx_data_o (uart_tx_data_o),
  .uart_tx_load_o (uart_tx_load_o)
);

// File: tb/test_lin_frame_buf.sv
`timescale 1ns/1ps
module test_lin_frame_buf;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       uart_mode_i = 1'b0;
  logic       sel_we_i = 1'b0;
  logic [3:0] sel_wdata_i = '0;
  logic [3:0] sel_rdata_o;
  logic       dat_we_i = 1'b0, dat_re_i = 1'b0;
  logic [7:0] dat_wdata_i = '0, dat_rdata_o;
  logic       frm_start_i = 1'b0, frm_rx_we_i = 1'b0, frm_tx_re_i = 1'b0;
  logic [7:0] frm_rx_data_i = '0, frm_tx_data_o;
  logic [2:0] frm_idx_o;
  logic       uart_rx_valid_i = 1'b0;
  logic [7:0] uart_rx_data_i = '0, uart_tx_data_o;
  logic       uart_tx_load_o;

  always #10 clk_i = ~clk_i;

  lin_frame_buf i_lin_frame_buf (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  // reference state
  logic [7:0] m_mem [8];
  logic [2:0] m_idx = '0, m_fidx = '0;
  logic       m_hold = 1'b0, m_load = 1'b0;
  logic [7:0] m_tx = '0, m_rx = '0;
  string      sel_tag = "R1";

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] inc3(logic [2:0] v);
    return (v == 3'd7) ? 3'd0 : v + 3'd1;
  endfunction

  // inputs are set by the caller just after a falling edge
  task automatic step();
    logic [2:0] eff;
    #1;
    eff = frm_start_i ? 3'd0 : m_fidx;
    if (!uart_mode_i) chk("R2", dat_rdata_o, m_mem[m_idx]);
    else              chk("R11", dat_rdata_o, m_rx);
    chk("R8", frm_tx_data_o, m_mem[eff]);
    // next state
    if (!uart_mode_i && dat_we_i) m_mem[m_idx] = dat_wdata_i;
    if (frm_rx_we_i) m_mem[eff] = frm_rx_data_i;
    if (frm_rx_we_i || frm_tx_re_i) m_fidx = inc3(eff);
    else if (frm_start_i) m_fidx = 3'd0;
    if (sel_we_i) begin
      sel_tag = "R6"; m_idx = sel_wdata_i[2:0]; m_hold = sel_wdata_i[3];
    end else if (uart_mode_i) sel_tag = "R10";
    else if ((dat_we_i || dat_re_i) && !m_hold) begin
      sel_tag = (m_idx == 3'd7) ? "R4" : "R3"; m_idx = inc3(m_idx);
    end else sel_tag = "R5";
    m_load = uart_mode_i && dat_we_i;
    if (m_load) m_tx = dat_wdata_i;
    if (uart_rx_valid_i) m_rx = uart_rx_data_i;
    @(negedge clk_i);
    chk(sel_tag, {4'd0, sel_rdata_o}, {4'd0, m_hold, m_idx});
    chk("R7", {5'd0, frm_idx_o}, {5'd0, m_fidx});
    chk("R10", uart_tx_data_o, m_tx);
    chk("R10", {7'd0, uart_tx_load_o}, {7'd0, m_load});
  endtask

  task automatic idle();
    sel_we_i = 0; dat_we_i = 0; dat_re_i = 0; frm_start_i = 0;
    frm_rx_we_i = 0; frm_tx_re_i = 0; uart_rx_valid_i = 0;
  endtask

  task automatic rnd(bit uart);
    idle();
    uart_mode_i     = uart;
    sel_we_i        = ($urandom % 10) == 0;
    sel_wdata_i     = 4'($urandom);
    dat_we_i        = ($urandom % 3) == 0;
    dat_re_i        = ($urandom % 3) == 0;
    dat_wdata_i     = 8'($urandom);
    frm_start_i     = ($urandom % 12) == 0;
    frm_rx_we_i     = ($urandom % 3) == 0;
    frm_tx_re_i     = ($urandom % 5) == 0;
    frm_rx_data_i   = 8'($urandom);
    uart_rx_valid_i = ($urandom % 4) == 0;
    uart_rx_data_i  = 8'($urandom);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state
    chk("R1", {4'd0, sel_rdata_o}, 8'd0);
    chk("R1", {5'd0, frm_idx_o}, 8'd0);
    chk("R1", uart_tx_data_o, 8'd0);
    chk("R1", {7'd0, uart_tx_load_o}, 8'd0);
    for (int i = 0; i < 8; i++) begin
      idle(); dat_re_i = 1; #1;
      chk("R1", dat_rdata_o, 8'd0);
      step();
    end
    // R4: fill by auto-increment from slot 5, wrapping past 7
    idle(); sel_we_i = 1; sel_wdata_i = 4'b0101; step();
    for (int i = 0; i < 9; i++) begin
      idle(); dat_we_i = 1; dat_wdata_i = 8'(8'h30 + i); step();
    end
    chk("R4", {4'd0, sel_rdata_o}, 8'h06);
    // R5: hold bit set, repeated reads stay put
    idle(); sel_we_i = 1; sel_wdata_i = 4'b1011; step();
    for (int i = 0; i < 4; i++) begin idle(); dat_re_i = 1; step(); end
    chk("R5", {4'd0, sel_rdata_o}, 8'h0B);
    // R6: select write together with an auto access
    idle(); sel_we_i = 1; sel_wdata_i = 4'b0010; step();
    idle(); sel_we_i = 1; sel_wdata_i = 4'b0110; dat_re_i = 1; step();
    chk("R6", {4'd0, sel_rdata_o}, 8'h06);
    // R7: frame start with a strobe, bytes land in order
    idle(); frm_start_i = 1; frm_rx_we_i = 1; frm_rx_data_i = 8'hA0; step();
    for (int i = 1; i < 4; i++) begin
      idle(); frm_rx_we_i = 1; frm_rx_data_i = 8'(8'hA0 + i); step();
    end
    chk("R7", {5'd0, frm_idx_o}, 8'd4);
    idle(); sel_we_i = 1; sel_wdata_i = 4'b0000; step();
    for (int i = 0; i < 4; i++) begin
      idle(); dat_re_i = 1; #1; chk("R7", dat_rdata_o, 8'(8'hA0 + i)); step();
    end
    // R9: collision at slot 4, frame data kept
    idle(); sel_we_i = 1; sel_wdata_i = 4'b1100; step();
    idle(); dat_we_i = 1; dat_wdata_i = 8'h11; frm_rx_we_i = 1; frm_rx_data_i = 8'h99; step();
    idle(); #1; chk("R9", dat_rdata_o, 8'h99); step();
    // R10/R11: UART mode leaves buffer and pointer alone
    idle(); uart_mode_i = 1; uart_rx_valid_i = 1; uart_rx_data_i = 8'h5A; step();
    idle(); dat_we_i = 1; dat_wdata_i = 8'hC3; dat_re_i = 1; #1;
    chk("R11", dat_rdata_o, 8'h5A); step();
    chk("R10", uart_tx_data_o, 8'hC3);
    idle(); uart_mode_i = 0; #1; chk("R10", dat_rdata_o, 8'h99); step();
    // random phases
    for (int p = 0; p < 6; p++)
      for (int i = 0; i < 600; i++) begin rnd(p % 3 == 2); step(); end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule